// File: doc/BRIEF.md
# Transmit FIFO with Automatic Start

This block holds the outgoing bytes of a contactless reader's transmit path in a twelve-entry byte queue. The host fills it through a small register window. It writes the number of bytes to send into two length registers, then pushes payload bytes into a data register. The three registers sit at consecutive addresses, so the host can load all of them in one sequential burst.

Writing the second length register arms the transmit controller. The controller raises a one-cycle start pulse toward the framer as soon as the queue holds a byte, so there is no separate go command. It then hands out one byte for each valid/ready handshake and counts the remaining bytes down. It pulses done when the last counted byte is taken. The host may keep refilling the queue while bytes drain.

A status register reports occupancy as the stored count minus one, an empty flag and a sticky overflow flag. A clear strobe empties the queue, wipes the length registers and the overflow flag, and aborts any transmission.

Top module: `txfifo_autostart`

## Requirements
- R1: The status register at address 0x1C reads bit 6 = 1 and bits 3:0 = 0 when the queue is empty. When it holds n bytes (1..12) it reads bit 6 = 0 and bits 3:0 = n-1. Bits 5:4 always read 0.
- R2: A write to the data register at 0x1F while 12 bytes are stored is dropped and sets status bit 7. Bit 7 stays set until the clear strobe. The dropped byte is never transmitted.
- R3: Address 0x1D holds count bits [11:4] and address 0x1E holds count bits [3:0] in bits 7:4, a partial-byte flag in bit 0 and a partial-byte bit count in bits 3:1. Both registers read back as written. The number of bytes sent is the count plus the flag.
- R4: A write to 0x1E with a nonzero byte total arms the controller. In the cycle after a byte is stored while armed, `tx_start` is high for exactly one cycle and `tx_valid` is high.
- R5: While sending, bytes leave in write order, one per cycle in which `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` stays high and `tx_data` stays stable. Bytes written during transmission are sent.
- R6: `tx_bits` reads 8 for each byte, except for the final byte when the partial-byte flag is set. For that byte it reads the partial-byte bit count.
- R7: After exactly the programmed number of handshakes, `tx_done` is high for one cycle, in the cycle after the last handshake. The controller then stops offering bytes, and any further bytes stay in the queue.
- R8: A `fifo_clr` pulse empties the queue, clears the overflow flag and both length registers, and aborts a transmission without a done pulse.
- R9: A byte total of zero does not arm the controller. Data written afterwards stays in the queue and no start pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Clear strobe: empty, clear lengths and overflow, abort |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 5 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr` (0 for the data port and unmapped addresses) |
| tx_start | output | 1 | One-cycle start pulse to the framer |
| tx_valid | output | 1 | A byte is offered to the framer |
| tx_data | output | 8 | Offered byte |
| tx_bits | output | 4 | Valid bits in the offered byte |
| tx_ready | input | 1 | Framer accepts the offered byte |
| tx_done | output | 1 | One-cycle pulse after the last counted byte |

## Verification
The bench builds the block with its default depth of 12 bytes. At that depth every occupancy code, including the full case and the dropped write, can be walked one byte at a time. Byte totals from 1 to 24 are swept under three framer ready patterns, with the partial-byte flag on every fourth total. These runs exceed the queue depth, so refilling during transmission, stalls, and leftover bytes after done are all exercised. Directed cases cover the start-pulse cycle, abort by clear, and the zero-length case.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_ARMED, TX_SEND} txf_state_e;
  localparam logic [4:0] A_STATUS = 5'h1C;
  localparam logic [4:0] A_LEN_HI = 5'h1D;
  localparam logic [4:0] A_LEN_LO = 5'h1E;
  localparam logic [4:0] A_DATA   = 5'h1F;
endpackage

// File: rtl/txf_store.sv
module txf_store #(
  parameter int DEPTH = 12,
  parameter int W     = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] occ,
  output logic          ovf_evt
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp, wp_n, rp_n;
  logic [CW-1:0] occ_n;
  logic          push_ok, pop_ok;

  always_comb begin
    push_ok = push && (occ != CW'(DEPTH));
    pop_ok  = pop && (occ != '0);
    ovf_evt = push && (occ == CW'(DEPTH));
    wp_n    = wp;
    rp_n    = rp;
    occ_n   = occ;
    if (push_ok) wp_n = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
    if (pop_ok)  rp_n = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
    if (push_ok && !pop_ok)      occ_n = occ + 1'b1;
    else if (pop_ok && !push_ok) occ_n = occ - 1'b1;
    if (clr) begin
      wp_n  = '0;
      rp_n  = '0;
      occ_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      occ <= occ_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wp] <= wdata;
  end

  assign head = mem[rp];
endmodule

// File: rtl/txf_regs.sv
module txf_regs
  import txf_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr,
  input  logic [4:0]    addr,
  input  logic [7:0]    wdata,
  input  logic [CW-1:0] occ,
  input  logic          ovf_evt,
  output logic [7:0]    len_hi,
  output logic [7:0]    len_lo,
  output logic          ovf,
  output logic [7:0]    rdata
);
  logic [7:0] len_hi_n, len_lo_n;
  logic       ovf_n, empty;
  logic [3:0] field;

  always_comb begin
    len_hi_n = len_hi;
    len_lo_n = len_lo;
    ovf_n    = ovf || ovf_evt;
    if (wr && addr == A_LEN_HI) len_hi_n = wdata;
    if (wr && addr == A_LEN_LO) len_lo_n = wdata;
    if (clr) begin
      len_hi_n = '0;
      len_lo_n = '0;
      ovf_n    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_hi <= '0;
      len_lo <= '0;
      ovf    <= 1'b0;
    end else begin
      len_hi <= len_hi_n;
      len_lo <= len_lo_n;
      ovf    <= ovf_n;
    end
  end

  always_comb begin
    empty = (occ == '0);
    field = empty ? 4'd0 : 4'(occ - 1'b1);
    case (addr)
      A_STATUS: rdata = {ovf, empty, 2'b00, field};
      A_LEN_HI: rdata = len_hi;
      A_LEN_LO: rdata = len_lo;
      default:  rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/txf_txctl.sv
module txf_txctl
  import txf_pkg::*;
#(
  parameter int LENW = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       arm,
  input  logic [7:0] lo_wdata,
  input  logic [7:0] len_hi,
  input  logic       occ_nz,
  input  logic       tx_ready,
  output logic       tx_start,
  output logic       tx_valid,
  output logic [3:0] tx_bits,
  output logic       pop,
  output logic       tx_done
);
  localparam int RW = LENW + 1;

  txf_state_e    st, st_n;
  logic [RW-1:0] rem, rem_n, total;
  logic          brk, brk_n, start_n, done_n;
  logic [2:0]    nb, nb_n;

  assign total    = {1'b0, len_hi, lo_wdata[7:4]} + RW'(lo_wdata[0]);
  assign tx_valid = (st == TX_SEND) && occ_nz;
  assign pop      = tx_valid && tx_ready;
  assign tx_bits  = (brk && rem == RW'(1)) ? {1'b0, nb} : 4'd8;

  always_comb begin
    st_n    = st;
    rem_n   = rem;
    brk_n   = brk;
    nb_n    = nb;
    start_n = 1'b0;
    done_n  = 1'b0;
    if (clr) begin
      st_n  = TX_IDLE;
      rem_n = '0;
    end else if (st != TX_SEND) begin
      if (arm) begin
        st_n  = (total != '0) ? TX_ARMED : TX_IDLE;
        rem_n = total;
        brk_n = lo_wdata[0];
        nb_n  = lo_wdata[3:1];
      end else if (st == TX_ARMED && occ_nz) begin
        st_n    = TX_SEND;
        start_n = 1'b1;
      end
    end else if (pop) begin
      rem_n = rem - 1'b1;
      if (rem == RW'(1)) begin
        st_n   = TX_IDLE;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= TX_IDLE;
      rem      <= '0;
      brk      <= 1'b0;
      nb       <= '0;
      tx_start <= 1'b0;
      tx_done  <= 1'b0;
    end else begin
      st       <= st_n;
      rem      <= rem_n;
      brk      <= brk_n;
      nb       <= nb_n;
      tx_start <= start_n;
      tx_done  <= done_n;
    end
  end
endmodule

// File: rtl/txfifo_autostart.sv
module txfifo_autostart
  import txf_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int LENW  = 12,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_clr,
  input  logic       host_wr,
  input  logic [4:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       tx_start,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic [3:0] tx_bits,
  input  logic       tx_ready,
  output logic       tx_done
);
  logic [CW-1:0] occ;
  logic          ovf, ovf_evt, pop, push, arm;
  logic [7:0]    len_hi, len_lo;

  assign push = host_wr && host_addr == A_DATA;
  assign arm  = host_wr && host_addr == A_LEN_LO;

  txf_store #(.DEPTH(DEPTH), .W(8), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(push), .wdata(host_wdata),
    .pop(pop), .head(tx_data), .occ(occ), .ovf_evt(ovf_evt)
  );

  txf_regs #(.DEPTH(DEPTH), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .wr(host_wr), .addr(host_addr),
    .wdata(host_wdata), .occ(occ), .ovf_evt(ovf_evt), .len_hi(len_hi),
    .len_lo(len_lo), .ovf(ovf), .rdata(host_rdata)
  );

  txf_txctl #(.LENW(LENW)) u_txctl (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .arm(arm), .lo_wdata(host_wdata),
    .len_hi(len_hi), .occ_nz(occ != '0), .tx_ready(tx_ready), .tx_start(tx_start),
    .tx_valid(tx_valid), .tx_bits(tx_bits), .pop(pop), .tx_done(tx_done)
  );
endmodule

// File: rtl/txf_chk.sv
module txf_chk
  import txf_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_clr,
  input logic          host_wr,
  input logic [4:0]    host_addr,
  input logic          tx_start,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_done,
  input logic [CW-1:0] occ,
  input logic          ovf
);
  // R1
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));
  // R2
  ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_DATA && occ == CW'(DEPTH) && !(tx_valid && tx_ready) && !fifo_clr)
    |=> (occ == CW'(DEPTH) && ovf));
  // R2
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !fifo_clr) |=> ovf);
  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);
  // R4
  start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> tx_valid);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !fifo_clr) |=> (tx_valid && $stable(tx_data)));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
  // R8
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (occ == '0 && !tx_valid && !tx_done && !ovf));
endmodule

bind txfifo_autostart txf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .host_wr(host_wr),
  .host_addr(host_addr), .tx_start(tx_start), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .tx_done(tx_done), .occ(occ), .ovf(ovf)
);

// File: tb/tb_txfifo_autostart.sv
module tb_txfifo_autostart;
  logic       clk, rst_n, fifo_clr, host_wr, tx_ready;
  logic [4:0] host_addr;
  logic [7:0] host_wdata, host_rdata, tx_data;
  logic [3:0] tx_bits;
  logic       tx_start, tx_valid, tx_done;

  int checks = 0, errors = 0;
  int nstart = 0, ndone = 0, ngot = 0, done_ngot = 0, cyc = 0, mode = 0;
  bit cons_en = 0;
  logic [7:0] got [64];
  logic [3:0] gotb [64];

  txfifo_autostart dut (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_start(tx_start), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_bits(tx_bits), .tx_ready(tx_ready), .tx_done(tx_done)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd_reg(logic [4:0] a, output logic [7:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic clr_pulse();
    @(negedge clk); fifo_clr = 1;
    @(negedge clk); fifo_clr = 0;
  endtask

  // framer model: decide ready, then record the handshake of the coming edge
  always @(negedge clk) begin
    if (tx_start) nstart++;
    if (tx_done) begin ndone++; done_ngot = ngot; end
    if (cons_en) begin
      cyc++;
      tx_ready = (mode == 0) || (mode == 1 && cyc % 2 == 0) || (mode == 2 && cyc % 3 == 0);
      #1;
      if (tx_valid && tx_ready && ngot < 64) begin
        got[ngot] = tx_data; gotb[ngot] = tx_bits; ngot++;
      end
    end else tx_ready = 0;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst_n = 0; fifo_clr = 0; host_wr = 0; host_addr = 0; host_wdata = 0; tx_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_reg(5'h1C, r);
    chk("R1 reset status", r, 8'h40);
    chk("R4 reset start/valid/done", {tx_start, tx_valid, tx_done}, 0);

    // R1/R2: walk the occupancy codes with no transmission armed
    for (int n = 1; n <= 12; n++) begin
      wr_reg(5'h1F, 8'(n));
      rd_reg(5'h1C, r);
      chk("R1 occupancy code", r, n - 1);
    end
    wr_reg(5'h1F, 8'hEE);
    rd_reg(5'h1C, r);
    chk("R2 overflow flag on full write", r, 8'h80 | 11);
    repeat (3) @(negedge clk);
    rd_reg(5'h1C, r);
    chk("R2 overflow sticky", r, 8'h8B);
    // send the 12 stored bytes; the dropped one must not appear
    ngot = 0; ndone = 0; nstart = 0; mode = 0; cons_en = 1;
    wr_reg(5'h1D, 8'h00);
    wr_reg(5'h1E, 8'hC0);
    for (int w = 0; w < 40 && ndone == 0; w++) @(negedge clk);
    chk("R2 bytes sent from full queue", ngot, 12);
    for (int i = 0; i < 12; i++) chk("R2 dropped byte absent", got[i], i + 1);
    cons_en = 0;
    clr_pulse();
    rd_reg(5'h1C, r);
    chk("R8 clear resets overflow", r, 8'h40);

    // R3: length readback
    wr_reg(5'h1D, 8'hA5);
    wr_reg(5'h1E, 8'h3D);
    rd_reg(5'h1D, r); chk("R3 length high readback", r, 8'hA5);
    rd_reg(5'h1E, r); chk("R3 length low readback", r, 8'h3D);
    clr_pulse();
    rd_reg(5'h1D, r); chk("R8 length high cleared", r, 0);
    rd_reg(5'h1E, r); chk("R8 length low cleared", r, 0);

    // R4: start timing, R5 hold while not ready, R8 abort
    nstart = 0; ndone = 0;
    wr_reg(5'h1D, 8'h00);
    wr_reg(5'h1E, 8'h20);
    wr_reg(5'h1F, 8'h5A);
    chk("R4 no start in storing cycle", tx_start, 0);
    @(negedge clk);
    chk("R4 start pulse", tx_start, 1);
    chk("R4 valid with start", tx_valid, 1);
    @(negedge clk);
    chk("R4 start is one cycle", tx_start, 0);
    repeat (3) @(negedge clk);
    chk("R5 held byte while not ready", {tx_valid, tx_data}, {1'b1, 8'h5A});
    clr_pulse();
    repeat (5) @(negedge clk);
    rd_reg(5'h1C, r);
    chk("R8 abort empties queue", r, 8'h40);
    chk("R8 abort no valid no done", {tx_valid, 8'(ndone)}, 0);
    wr_reg(5'h1F, 8'h11);
    repeat (4) @(negedge clk);
    chk("R8 no restart after abort", tx_valid, 0);
    clr_pulse();

    // R9: zero total
    nstart = 0;
    wr_reg(5'h1D, 8'h00);
    wr_reg(5'h1E, 8'h00);
    wr_reg(5'h1F, 8'h77);
    repeat (5) @(negedge clk);
    rd_reg(5'h1C, r);
    chk("R9 zero length keeps data", r, 8'h00);
    chk("R9 zero length no start", nstart, 0);

    // R5/R6/R7 sweep over totals and ready patterns
    for (int L = 1; L <= 24; L++) begin
      int brk, nbits, total, bad;
      brk = (L % 4 == 0) ? 1 : 0;
      nbits = L % 7 + 1;
      total = L + brk;
      clr_pulse();
      nstart = 0; ndone = 0; ngot = 0; mode = L % 3;
      wr_reg(5'h1D, 8'(L >> 4));
      wr_reg(5'h1E, {4'(L), 3'(nbits), 1'(brk)});
      cons_en = 1;
      for (int i = 0; i < total + 2; i++) begin
        rd_reg(5'h1C, r);
        while (r == 8'h0B || r == 8'h8B) begin
          @(negedge clk);
          rd_reg(5'h1C, r);
        end
        wr_reg(5'h1F, 8'(L * 7 + i));
      end
      for (int w = 0; w < 200 && ndone == 0; w++) @(negedge clk);
      repeat (4) @(negedge clk);
      cons_en = 0;
      chk("R4 one start per transmission", nstart, 1);
      chk("R7 one done pulse", ndone, 1);
      chk("R7 done after last handshake", done_ngot, total);
      chk("R7 handshake count", ngot, total);
      bad = 0;
      for (int i = 0; i < total; i++) if (got[i] !== 8'(L * 7 + i)) bad++;
      chk("R5 byte order with refill", bad, 0);
      bad = 0;
      for (int i = 0; i < total - 1; i++) if (gotb[i] !== 4'd8) bad++;
      chk("R6 full bytes report 8", bad, 0);
      chk("R6 last byte bit count", gotb[total - 1], brk ? nbits : 8);
      rd_reg(5'h1C, r);
      chk("R7 leftover bytes remain", r, 8'h01);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule